// File: doc/BRIEF.md
# Idle State Selector

This block picks the low-power state a processor should enter when it goes idle. It keeps a small table of candidate states, ordered from shallowest (index 0) to deepest (highest index). Each table entry holds an entry latency, an exit latency, a break-even residency, an optional explicit wake-up latency, a has-wake-up-latency flag and a valid flag. All times are unsigned 32-bit microsecond counts. Software fills the table through a write-only register port that takes an index, a field code and a data word.

For each selection request the caller supplies two values: the predicted time until the next wake-up, and the largest wake-up latency the system can accept. The block then checks every entry in parallel, registers the result, and raises a one-cycle valid pulse on the next clock edge. The result code is 0 when plain wait-for-interrupt standby is the answer. That standby state is implicit and is never stored in the table. A result code of k+1 means table entry k was chosen.

Top module: `idle_state_selector`

## Requirements
- R1: After a synchronous active-low reset, `sel_valid` is 0, `sel_state` is 0 and every table entry is invalid, so any request returns 0.
- R2: `sel_valid` is 1 exactly in the cycle after a cycle with `sel_req` high. `sel_state` keeps its value while no request is made.
- R3: An entry qualifies only when the predicted time is greater than or equal to its minimum residency. Equality qualifies.
- R4: The effective wake-up latency of an entry is its programmed wake-up latency when flags bit 1 is set. Otherwise it is entry latency plus exit latency, summed without wrap-around (33-bit).
- R5: An entry whose effective wake-up latency is greater than `sel_lat_limit` never qualifies. Equality qualifies.
- R6: Among qualifying entries the deepest one (highest index k) is chosen, and the result code is k+1.
- R7: When no entry qualifies, the result code is 0 (wait-for-interrupt).
- R8: An entry whose valid flag (flags bit 0) is 0 never qualifies.
- R9: The field codes are 0 entry latency, 1 exit latency, 2 minimum residency, 3 wake-up latency and 4 flags. A write with a field code above 4, or with an index of `NUM_STATES` or more, changes nothing.
- R10: A write takes effect for requests in the following cycle. A request made in the same cycle as a write is evaluated against the old table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W+1 | Table entry index for the write |
| cfg_field | input | 3 | Field code for the write |
| cfg_wdata | input | 32 | Write data |
| sel_req | input | 1 | Selection request |
| sel_predicted | input | 32 | Predicted idle time in microseconds |
| sel_lat_limit | input | 32 | Largest acceptable wake-up latency in microseconds |
| sel_valid | output | 1 | One-cycle pulse when a result is available |
| sel_state | output | CODE_W | 0 means wait-for-interrupt; k+1 means table entry k |

## Verification
A wrong table entry or a faulty qualification term shows up as a wrong `sel_state` on the very next request. Such a request either returns a shallower state, returns a deeper state, or falls back to 0. The result appears one cycle after the request, so a fault is visible one cycle after the first request whose predicted time and latency limit straddle the affected threshold. The bench therefore sweeps both inputs across grids that cross every residency and latency boundary of a programmed table. It also covers the boundary equalities, the latency sum that would overflow 32 bits, ignored writes, and a write that collides with a request in the same cycle.

// File: rtl/idle_sel_pkg.sv
// Package: shared widths, field codes and the table entry type for the
// idle state selector. Assumes 32-bit microsecond time values.
package idle_sel_pkg;

    localparam int TIME_W  = 32;
    localparam int FIELD_W = 3;

    // Field codes for the table write port (R9)
    typedef enum logic [FIELD_W-1:0] {
        FLD_ENTRY  = 3'd0,
        FLD_EXIT   = 3'd1,
        FLD_MINRES = 3'd2,
        FLD_WAKE   = 3'd3,
        FLD_FLAGS  = 3'd4
    } field_e;

    // One candidate low-power state
    typedef struct packed {
        logic              valid;
        logic              has_wake;
        logic [TIME_W-1:0] entry_lat;
        logic [TIME_W-1:0] exit_lat;
        logic [TIME_W-1:0] min_res;
        logic [TIME_W-1:0] wake_lat;
    } idle_entry_t;

endpackage

// File: rtl/idle_state_table.sv
// Module: register storage for the candidate state table.
// Writes land on the clock edge. An out-of-range index or an unknown field
// code leaves the table untouched. Reset clears every entry.
module idle_state_table
    import idle_sel_pkg::*;
#(
    parameter  int NUM_STATES = 8,
    localparam int IDX_W      = $clog2(NUM_STATES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W:0]    cfg_idx,
    input  logic [FIELD_W-1:0] cfg_field,
    input  logic [TIME_W-1:0] cfg_wdata,
    output idle_entry_t       tbl [NUM_STATES]
);

    idle_entry_t       tbl_q [NUM_STATES];
    logic              idx_ok;
    logic [IDX_W-1:0]  slot;

    // Decode whether the write addresses a real entry
    always_comb begin
        idx_ok = (cfg_idx < (IDX_W+1)'(NUM_STATES));
        slot   = cfg_idx[IDX_W-1:0];
    end

    // Table update: one field of one entry per write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_STATES; i++) tbl_q[i] <= '0;
        end else if (cfg_we && idx_ok) begin
            case (cfg_field)
                FLD_ENTRY:  tbl_q[slot].entry_lat <= cfg_wdata;
                FLD_EXIT:   tbl_q[slot].exit_lat  <= cfg_wdata;
                FLD_MINRES: tbl_q[slot].min_res   <= cfg_wdata;
                FLD_WAKE:   tbl_q[slot].wake_lat  <= cfg_wdata;
                FLD_FLAGS: begin
                    tbl_q[slot].valid    <= cfg_wdata[0];
                    tbl_q[slot].has_wake <= cfg_wdata[1];
                end
                default: ;
            endcase
        end
    end

    assign tbl = tbl_q;

    // Per-entry write checks
    for (genvar g = 0; g < NUM_STATES; g++) begin : g_chk
        assert_flags_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_idx == (IDX_W+1)'(g) && cfg_field == FLD_FLAGS)
            |=> (tbl_q[g].valid == $past(cfg_wdata[0])));
        assert_minres_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_idx == (IDX_W+1)'(g) && cfg_field == FLD_MINRES)
            |=> (tbl_q[g].min_res == $past(cfg_wdata)));
    end

endmodule

// File: rtl/idle_state_qualify.sv
// Module: combinational per-entry qualification.
// An entry qualifies when it is valid, the predicted time covers its
// break-even residency, and its effective wake-up latency fits the limit.
// The latency sum is formed one bit wider so that it cannot wrap.
module idle_state_qualify
    import idle_sel_pkg::*;
#(
    parameter int NUM_STATES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  idle_entry_t           tbl [NUM_STATES],
    input  logic [TIME_W-1:0]     predicted,
    input  logic [TIME_W-1:0]     lat_limit,
    output logic [NUM_STATES-1:0] qual
);

    for (genvar g = 0; g < NUM_STATES; g++) begin : g_ent
        logic [TIME_W:0] eff_lat;
        logic            res_ok;
        logic            lat_ok;

        // Effective latency: explicit value or entry+exit (R4)
        always_comb begin
            if (tbl[g].has_wake) eff_lat = {1'b0, tbl[g].wake_lat};
            else                 eff_lat = {1'b0, tbl[g].entry_lat} + {1'b0, tbl[g].exit_lat};
            res_ok  = (predicted >= tbl[g].min_res);
            lat_ok  = (eff_lat <= {1'b0, lat_limit});
            qual[g] = tbl[g].valid && res_ok && lat_ok;
        end

        assert_residency_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (predicted < tbl[g].min_res) |-> !qual[g]);
        assert_latency_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (tbl[g].has_wake && tbl[g].wake_lat > lat_limit) |-> !qual[g]);
        assert_invalid_skipped_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !tbl[g].valid |-> !qual[g]);
    end

endmodule

// File: rtl/idle_state_pick.sv
// Module: deepest-qualifier priority pick and output register.
// Code 0 means wait-for-interrupt; code k+1 means entry k. The result and
// a one-cycle valid pulse are registered on the edge that samples sel_req.
module idle_state_pick #(
    parameter  int NUM_STATES = 8,
    localparam int CODE_W     = $clog2(NUM_STATES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_req,
    input  logic [NUM_STATES-1:0] qual,
    output logic                  sel_valid,
    output logic [CODE_W-1:0]     sel_state
);

    logic [CODE_W-1:0] code_d;

    // Priority encode: later (deeper) qualifying entries override earlier
    always_comb begin
        code_d = '0;
        for (int i = 0; i < NUM_STATES; i++) begin
            if (qual[i]) code_d = CODE_W'(i + 1);
        end
    end

    // Output register: capture on request, pulse valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid <= 1'b0;
            sel_state <= '0;
        end else begin
            sel_valid <= sel_req;
            if (sel_req) sel_state <= code_d;
        end
    end

    assert_pulse_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_req |=> sel_valid);
    assert_quiet_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_req |=> (!sel_valid && $stable(sel_state)));
    assert_default_when_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_req && qual == '0) |=> (sel_state == '0));
    assert_deepest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_req && qual[NUM_STATES-1]) |=> (sel_state == CODE_W'(NUM_STATES)));

endmodule

// File: rtl/idle_state_selector.sv
// Module: top of the idle state selector.
// Ties the table, the qualification array and the pick/register stage
// together. Assumes a single clock and a synchronous active-low reset.
module idle_state_selector
    import idle_sel_pkg::*;
#(
    parameter  int NUM_STATES = 8,
    localparam int IDX_W      = $clog2(NUM_STATES),
    localparam int CODE_W     = $clog2(NUM_STATES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W:0]     cfg_idx,
    input  logic [FIELD_W-1:0] cfg_field,
    input  logic [TIME_W-1:0]  cfg_wdata,
    input  logic               sel_req,
    input  logic [TIME_W-1:0]  sel_predicted,
    input  logic [TIME_W-1:0]  sel_lat_limit,
    output logic               sel_valid,
    output logic [CODE_W-1:0]  sel_state
);

    idle_entry_t           tbl [NUM_STATES];
    logic [NUM_STATES-1:0] qual;

    idle_state_table #(.NUM_STATES(NUM_STATES)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .tbl       (tbl)
    );

    idle_state_qualify #(.NUM_STATES(NUM_STATES)) u_qualify (
        .clk       (clk),
        .rst_n     (rst_n),
        .tbl       (tbl),
        .predicted (sel_predicted),
        .lat_limit (sel_lat_limit),
        .qual      (qual)
    );

    idle_state_pick #(.NUM_STATES(NUM_STATES)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_req   (sel_req),
        .qual      (qual),
        .sel_valid (sel_valid),
        .sel_state (sel_state)
    );

    assert_result_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (sel_state <= CODE_W'(NUM_STATES)));

endmodule

// File: tb/tb_idle_state_selector.sv
// Bench: keeps its own model of the table and computes expected choices
// arithmetically, then sweeps predicted time and latency limit on a grid.
module tb_idle_state_selector;

    localparam int N      = 8;
    localparam int IDX_W  = $clog2(N);
    localparam int CODE_W = $clog2(N + 1);

    logic              clk = 0;
    logic              rst_n = 0;
    logic              cfg_we = 0;
    logic [IDX_W:0]    cfg_idx = '0;
    logic [2:0]        cfg_field = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              sel_req = 0;
    logic [31:0]       sel_predicted = '0;
    logic [31:0]       sel_lat_limit = '0;
    logic              sel_valid;
    logic [CODE_W-1:0] sel_state;

    int errors = 0;
    int checks = 0;

    // bench model of the table
    logic [31:0] m_ent [N];
    logic [31:0] m_ext [N];
    logic [31:0] m_min [N];
    logic [31:0] m_wk  [N];
    logic        m_val [N];
    logic        m_hw  [N];

    always #5 clk = ~clk;

    idle_state_selector #(.NUM_STATES(N)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .sel_req(sel_req),
        .sel_predicted(sel_predicted), .sel_lat_limit(sel_lat_limit),
        .sel_valid(sel_valid), .sel_state(sel_state)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_pick(input logic [31:0] pred, input logic [31:0] lim);
        int r = 0;
        for (int i = 0; i < N; i++) begin
            logic [32:0] eff;
            eff = m_hw[i] ? {1'b0, m_wk[i]} : ({1'b0, m_ent[i]} + {1'b0, m_ext[i]});
            if (m_val[i] && pred >= m_min[i] && eff <= {1'b0, lim}) r = i + 1;
        end
        return r;
    endfunction

    function automatic void model_write(input int idx, input int fld, input logic [31:0] d);
        if (idx < N) begin
            case (fld)
                0: m_ent[idx] = d;
                1: m_ext[idx] = d;
                2: m_min[idx] = d;
                3: m_wk[idx]  = d;
                4: begin m_val[idx] = d[0]; m_hw[idx] = d[1]; end
                default: ;
            endcase
        end
    endfunction

    task automatic wr(input int idx, input int fld, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_idx = (IDX_W+1)'(idx); cfg_field = 3'(fld); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        model_write(idx, fld, d);
    endtask

    task automatic sel(input logic [31:0] pred, input logic [31:0] lim, input string tag);
        int exp;
        exp = model_pick(pred, lim);
        @(negedge clk);
        sel_req = 1; sel_predicted = pred; sel_lat_limit = lim;
        @(negedge clk);
        sel_req = 0;
        chk(sel_valid == 1'b1, {tag, " valid"}, int'(sel_valid), 1);
        chk(int'(sel_state) == exp, tag, int'(sel_state), exp);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_ent[i] = 0; m_ext[i] = 0; m_min[i] = 0; m_wk[i] = 0; m_val[i] = 0; m_hw[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(sel_valid == 1'b0, "R1 valid after reset", int'(sel_valid), 0);
        chk(sel_state == '0, "R1 state after reset", int'(sel_state), 0);
        sel(32'd1000, 32'd1000, "R1 empty table");

        // R9 ignored writes: index out of range, unknown field code
        wr(N, 4, 32'd1);
        sel(32'd1000, 32'd1000, "R9 index out of range ignored");
        wr(0, 5, 32'd3);
        wr(0, 7, 32'd1);
        sel(32'd1000, 32'd1000, "R9 unknown field ignored");

        // R4/R5 overflow: entry+exit wraps in 32 bits, must not qualify
        wr(0, 0, 32'hFFFF_FFFF);
        wr(0, 1, 32'd2);
        wr(0, 2, 32'd0);
        wr(0, 4, 32'd1);
        sel(32'd5, 32'hFFFF_FFFF, "R4 no wrap of latency sum");
        // explicit wake latency replaces the sum
        wr(0, 3, 32'd10);
        wr(0, 4, 32'd3);
        sel(32'd5, 32'd10, "R4 explicit wake latency equal limit R5");
        sel(32'd5, 32'd9, "R5 limit just below");

        // R10 write and request in the same cycle see the old table
        @(negedge clk);
        cfg_we = 1; cfg_idx = '0; cfg_field = 3'd4; cfg_wdata = 32'd0;
        sel_req = 1; sel_predicted = 32'd5; sel_lat_limit = 32'd10;
        @(negedge clk);
        cfg_we = 0; sel_req = 0;
        chk(sel_state == CODE_W'(1), "R10 same-cycle write uses old table", int'(sel_state), 1);
        model_write(0, 4, 32'd0);
        sel(32'd5, 32'd10, "R10 write seen next request R8");

        // Program a sweep table
        for (int i = 0; i < N; i++) begin
            wr(i, 0, 32'(5 * (i + 1)));
            wr(i, 1, 32'(7 * (i + 1) + (i % 3)));
            wr(i, 2, 32'(20 * (i + 1) + i));
            wr(i, 3, 32'(9 * (i + 1)));
            wr(i, 4, {30'd0, 1'(i % 2), 1'(i != 5)});
        end
        // R3 equality, R6 deepest
        sel(32'(20 * 3 + 2), 32'd1000, "R3 residency equality R6");
        sel(32'(20 * 3 + 1), 32'd1000, "R3 residency one below");
        sel(32'd10_000, 32'd1000, "R6 deepest chosen");
        sel(32'd0, 32'd0, "R7 nothing qualifies");

        // R2 state holds while idle
        @(negedge clk);
        chk(sel_valid == 1'b0, "R2 valid drops", int'(sel_valid), 0);
        chk(sel_state == '0, "R2 state held", int'(sel_state), 0);

        // Grid sweep: R3 R5 R6 R7 R8
        for (int p = 0; p < 200; p += 3) begin
            for (int l = 0; l < 145; l += 5) begin
                sel(32'(p), 32'(l), "R6 sweep");
            end
        end
        finish_run();
    end

endmodule